// File: doc/BRIEF.md
# Programmable Synchronous Serial Frame Transmitter

This block is the master side of a synchronous serial port. On a start request it loads a parallel word of 4 to 16 bits and shifts it out on a transmit data line, most significant bit first. While it shifts, it generates the serial bit clock and a frame signal. It samples a receive data line on the opposite clock edge, so one frame also collects a word from the far end. The received word is returned with a one-cycle completion pulse.

The bit clock is the system clock divided by an even ratio, set by a half-period count. A two-bit clock mode sets two things independently: the level the clock idles at, and whether data is launched on the rising or the falling edge. The frame signal can be active high or active low. After the last bit, the data line either falls to zero or keeps bit 0, as selected. A disable input drops the port back to idle immediately.

The controller is a three-state machine. The states are IDLE, DRIVE (first half of a bit, data launched) and SAMPLE (second half of a bit, data captured). Its transitions are:

- IDLE to DRIVE on an accepted start.
- DRIVE to SAMPLE when a half period expires.
- SAMPLE to DRIVE when a half period expires and bits remain.
- SAMPLE to IDLE when a half period expires on the last bit.
- Any state to IDLE when the port is disabled.

Top module: `sfm_top`

## Requirements
- R1: `clk_mode` sets the serial clock levels. While no frame is active, `sclk` sits at `clk_mode[1]`. During the first half of every bit (the launch half) `sclk` is `clk_mode[1]^clk_mode[0]`, and during the second half (the capture half) it is the inverse. The four codes are therefore: 00 launches on the falling edge and idles low; 01 launches on the rising edge and idles low; 10 launches on the rising edge and idles high; 11 launches on the falling edge and idles high.
- R2: Each half of a bit lasts `half_div` system cycles, so the bit period is 2*`half_div`. A `half_div` of 0 is treated as 1. The value is taken when the frame starts.
- R3: `txd` carries bit N-1 of `tx_word` first and bit 0 last, where N is the effective size. It changes only at the start of a launch half.
- R4: After the last bit, with `end_hold`=0, `txd` is 0 through the idle period. With `end_hold`=1, `txd` keeps the value of bit 0 through the idle period.
- R5: `sfrm` equals `frame_pol` while a frame is active. At all other times it equals the inverse of `frame_pol`.
- R6: A frame is active for exactly N*2*`half_div` cycles, starting the cycle after the start is accepted.
- R7: The effective size N is `data_size` clamped to the range 4..16. Values below 4 give 4 bits and values above 16 give 16 bits.
- R8: `start` is accepted only when `busy` is low and `enable` is high. `busy` is high from the cycle after acceptance until the frame ends. A `start` pulse during a frame has no effect.
- R9: `rxd` is sampled at the end of each launch half, most significant bit first. In the cycle after the frame ends, `done` is high for exactly one cycle and `rx_word` holds the N received bits right-aligned, with the upper bits zero.
- R10: With `enable` low, `txd` is 0, `sclk` sits at its idle level and `sfrm` is inactive in the same cycle. The next cycle `busy` is low, any frame in progress is dropped, and no `done` is produced for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enable |
| start | input | 1 | Start-of-frame request |
| tx_word | input | 16 | Word to transmit |
| data_size | input | 5 | Bits per frame (clamped to 4..16) |
| half_div | input | 8 | System cycles per half bit |
| clk_mode | input | 2 | Clock idle level and launch edge |
| frame_pol | input | 1 | Active level of the frame signal |
| end_hold | input | 1 | 1: keep last bit after the frame, 0: drive low |
| rxd | input | 1 | Serial receive data |
| sclk | output | 1 | Serial bit clock |
| sfrm | output | 1 | Frame signal |
| txd | output | 1 | Serial transmit data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame-complete pulse |
| rx_word | output | 16 | Received word, right-aligned |

## Verification
The bound checker enforces four properties on every cycle:

- The frame signal is inactive and the clock is at idle whenever the port is not busy.
- `done` lasts one cycle and follows a busy cycle.
- Every rise of `busy` traces back to an enabled start.
- Across the end of a frame, the data line stays at bit 0 in hold mode and falls to zero otherwise.

Only the directed scenarios can show the cycle-exact clock waveform for each mode, the bit order on the line, the length of the frame, size clamping, the received word, and the effect of a start during a frame or of disabling mid-frame.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRIVE  = 2'd1,
        ST_SAMPLE = 2'd2
    } sfm_state_e;

    // level of the serial clock while no frame runs
    function automatic logic idle_level(input logic [1:0] mode);
        return mode[1];
    endfunction

    // level of the serial clock during the launch half of a bit
    function automatic logic launch_level(input logic [1:0] mode);
        return mode[1] ^ mode[0];
    endfunction

endpackage

// File: rtl/sfm_halfcnt.sv
module sfm_halfcnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          half_end
);

    logic [CW-1:0] cnt;

    assign half_end = run && (cnt == limit - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= half_end ? '0 : cnt + CW'(1);
        end
    end

endmodule

// File: rtl/sfm_fsm.sv
module sfm_fsm
    import sfm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       start,
    input  logic       half_end,
    input  logic       last_bit,
    output sfm_state_e state,
    output logic       accept,
    output logic       capture,
    output logic       advance,
    output logic       finish
);

    sfm_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (enable && start) state_nx = ST_DRIVE;
            ST_DRIVE:  if (half_end) state_nx = ST_SAMPLE;
            ST_SAMPLE: if (half_end) state_nx = last_bit ? ST_IDLE : ST_DRIVE;
            default:   state_nx = ST_IDLE;
        endcase
        if (!enable) state_nx = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        accept  = 1'b0;
        capture = 1'b0;
        advance = 1'b0;
        finish  = 1'b0;
        unique case (state)
            ST_IDLE:   accept  = enable && start;
            ST_DRIVE:  capture = enable && half_end;
            ST_SAMPLE: begin
                advance = enable && half_end && !last_bit;
                finish  = enable && half_end && last_bit;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sfm_txshift.sv
module sfm_txshift #(
    parameter int W  = 16,
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [SW-1:0] size,
    input  logic [W-1:0]  word,
    input  logic          shift,
    input  logic          finish,
    output logic          bit_out,
    output logic          held
);

    logic [W-1:0] sh;

    assign bit_out = sh[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            held <= 1'b0;
        end else begin
            if (load)       sh <= word << (W - int'(size));
            else if (shift) sh <= sh << 1;
            if (finish)     held <= sh[W-1];
        end
    end

endmodule

// File: rtl/sfm_rxshift.sv
module sfm_rxshift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         capture,
    input  logic         rxd,
    input  logic         finish,
    output logic [W-1:0] rx_word,
    output logic         done
);

    logic [W-1:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            rx_word <= '0;
            done    <= 1'b0;
        end else begin
            if (clear)        acc <= '0;
            else if (capture) acc <= {acc[W-2:0], rxd};
            if (finish)       rx_word <= acc;
            done <= finish;
        end
    end

endmodule

// File: rtl/sfm_top.sv
module sfm_top
    import sfm_pkg::*;
#(
    parameter int MAX_W  = 16,
    parameter int MIN_W  = 4,
    parameter int DIV_W  = 8,
    localparam int SIZE_W = $clog2(MAX_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  logic [MAX_W-1:0]  tx_word,
    input  logic [SIZE_W-1:0] data_size,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [1:0]        clk_mode,
    input  logic              frame_pol,
    input  logic              end_hold,
    input  logic              rxd,
    output logic              sclk,
    output logic              sfrm,
    output logic              txd,
    output logic              busy,
    output logic              done,
    output logic [MAX_W-1:0]  rx_word
);

    sfm_state_e        state;
    logic              accept, capture, advance, finish, half_end;
    logic [SIZE_W-1:0] size_eff, bits_left;
    logic [DIV_W-1:0]  half_lat;
    logic              bit_out, held, active;

    always_comb begin
        if (data_size < SIZE_W'(MIN_W))      size_eff = SIZE_W'(MIN_W);
        else if (data_size > SIZE_W'(MAX_W)) size_eff = SIZE_W'(MAX_W);
        else                                 size_eff = data_size;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_left <= '0;
            half_lat  <= DIV_W'(1);
        end else if (accept) begin
            bits_left <= size_eff - SIZE_W'(1);
            half_lat  <= (half_div == '0) ? DIV_W'(1) : half_div;
        end else if (advance) begin
            bits_left <= bits_left - SIZE_W'(1);
        end
    end

    sfm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .start    (start),
        .half_end (half_end),
        .last_bit (bits_left == '0),
        .state    (state),
        .accept   (accept),
        .capture  (capture),
        .advance  (advance),
        .finish   (finish)
    );

    sfm_halfcnt #(.CW(DIV_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (accept),
        .run      (state != ST_IDLE),
        .limit    (half_lat),
        .half_end (half_end)
    );

    sfm_txshift #(.W(MAX_W), .SW(SIZE_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .size    (size_eff),
        .word    (tx_word),
        .shift   (advance),
        .finish  (finish),
        .bit_out (bit_out),
        .held    (held)
    );

    sfm_rxshift #(.W(MAX_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .capture (capture),
        .rxd     (rxd),
        .finish  (finish),
        .rx_word (rx_word),
        .done    (done)
    );

    assign active = enable && (state != ST_IDLE);
    assign busy   = (state != ST_IDLE);

    always_comb begin
        sfrm = ~frame_pol;
        sclk = idle_level(clk_mode);
        txd  = 1'b0;
        if (active) begin
            sfrm = frame_pol;
            sclk = launch_level(clk_mode) ^ (state == ST_SAMPLE);
            txd  = bit_out;
        end else if (enable) begin
            txd  = end_hold & held;
        end
    end

endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
    parameter int MAX_W  = 16,
    parameter int SIZE_W = 5,
    parameter int DIV_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              start,
    input logic [MAX_W-1:0]  tx_word,
    input logic [SIZE_W-1:0] data_size,
    input logic [DIV_W-1:0]  half_div,
    input logic [1:0]        clk_mode,
    input logic              frame_pol,
    input logic              end_hold,
    input logic              rxd,
    input logic              sclk,
    input logic              sfrm,
    input logic              txd,
    input logic              busy,
    input logic              done,
    input logic [MAX_W-1:0]  rx_word
);

    assert_frame_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sfrm == !frame_pol));

    assert_clock_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == clk_mode[1]));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(start) && $past(enable)));

    assert_end_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && enable && end_hold && $past(enable) && $stable(end_hold))
        |-> (txd == $past(txd)));

    assert_end_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && enable && !end_hold) |-> !txd);

endmodule

bind sfm_top sfm_checker #(.MAX_W(MAX_W), .SIZE_W(SIZE_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/sfm_top_bench.sv
module sfm_top_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        start = 1'b0;
    logic [15:0] tx_word = '0;
    logic [4:0]  data_size = 5'd8;
    logic [7:0]  half_div = 8'd1;
    logic [1:0]  clk_mode = 2'b00;
    logic        frame_pol = 1'b1;
    logic        end_hold = 1'b0;
    logic        rxd = 1'b0;
    logic        sclk, sfrm, txd, busy, done;
    logic [15:0] rx_word;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfm_top u_sfm_top (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .tx_word(tx_word), .data_size(data_size), .half_div(half_div),
        .clk_mode(clk_mode), .frame_pol(frame_pol), .end_hold(end_hold),
        .rxd(rxd), .sclk(sclk), .sfrm(sfrm), .txd(txd), .busy(busy),
        .done(done), .rx_word(rx_word)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one frame, checked at every negedge; glitch adds a start pulse mid-frame
    task automatic run_frame(input logic [15:0] word, input int size_in,
                             input logic [1:0] mode, input bit pol, input bit hold,
                             input int hd, input logic [15:0] rxpat, input bit glitch);
        int n_bits = (size_in < 4) ? 4 : (size_in > 16) ? 16 : size_in;
        int h = (hd == 0) ? 1 : hd;
        int total = n_bits * 2 * h;
        int bad_clk = 0, bad_frm = 0, bad_tx = 0, bad_busy = 0, bad_done = 0;
        logic [15:0] mask = 16'((32'h1 << n_bits) - 1);
        @(negedge clk);
        tx_word = word; data_size = 5'(size_in); clk_mode = mode;
        frame_pol = pol; end_hold = hold; half_div = 8'(hd); start = 1'b1;
        for (int n = 0; n < total; n++) begin
            int b = n / (2 * h);
            bit ph = (n % (2 * h)) >= h;
            @(negedge clk);
            if (sclk !== ((mode[1] ^ mode[0]) ^ ph)) bad_clk++;
            if (sfrm !== pol) bad_frm++;
            if (txd !== word[n_bits-1-b]) bad_tx++;
            if (busy !== 1'b1) bad_busy++;
            if (done !== 1'b0) bad_done++;
            if (n % (2 * h) == 0) rxd = rxpat[n_bits-1-b];
            start = (glitch && n == 3);
        end
        chk(bad_clk == 0, "R1", "clock waveform mismatches", bad_clk, 0);
        chk(bad_clk == 0, "R2", "half period length", bad_clk, 0);
        chk(bad_frm == 0, "R5", "frame active level mismatches", bad_frm, 0);
        chk(bad_tx == 0, "R3", "txd bit order mismatches", bad_tx, 0);
        chk(bad_busy == 0, "R6", "frame length, busy low early", bad_busy, 0);
        chk(bad_done == 0, "R9", "done inside frame", bad_done, 0);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R6", "busy after last bit", busy, 0);
        chk(done == 1'b1, "R9", "done pulse", done, 1);
        chk(rx_word == (rxpat & mask), "R9", "rx_word", rx_word, rxpat & mask);
        chk(sfrm == !pol, "R5", "frame inactive after end", sfrm, !pol);
        chk(sclk == mode[1], "R1", "clock idle level", sclk, mode[1]);
        chk(txd == (hold & word[0]), "R4", "txd after frame", txd, hold & word[0]);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done one cycle", done, 0);
        chk(busy == 1'b0, "R8", "mid-frame start ignored", busy, 0);
        chk(txd == (hold & word[0]), "R4", "txd idle hold", txd, hold & word[0]);
    endtask

    task automatic t_reset;
        chk(busy == 1'b0, "R8", "reset busy", busy, 0);
        chk(done == 1'b0, "R9", "reset done", done, 0);
        chk(sclk == 1'b0, "R1", "reset clock idle", sclk, 0);
        chk(sfrm == 1'b0, "R5", "reset frame inactive", sfrm, 0);
        chk(txd == 1'b0, "R10", "disabled txd", txd, 0);
    endtask

    task automatic t_start_disabled;
        @(negedge clk);
        enable = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R8", "start while disabled", busy, 0);
        chk(sfrm == !frame_pol, "R10", "frame while disabled", sfrm, !frame_pol);
        enable = 1'b1;
    endtask

    task automatic t_disable_mid;
        int seen_done = 0;
        @(negedge clk);
        tx_word = 16'hFFFF; data_size = 5'd8; half_div = 8'd2;
        clk_mode = 2'b10; frame_pol = 1'b1; end_hold = 1'b1; start = 1'b1;
        repeat (5) @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8", "frame running", busy, 1);
        enable = 1'b0;
        #1;
        chk(txd == 1'b0, "R10", "txd on disable", txd, 0);
        chk(sclk == 1'b1, "R10", "sclk idle on disable", sclk, 1);
        chk(sfrm == 1'b0, "R10", "sfrm on disable", sfrm, 0);
        @(negedge clk);
        chk(busy == 1'b0, "R10", "busy after disable", busy, 0);
        repeat (40) begin
            @(negedge clk);
            if (done) seen_done++;
        end
        chk(seen_done == 0, "R10", "no done for dropped frame", seen_done, 0);
        enable = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        enable = 1'b1;
        run_frame(16'h00A5, 8, 2'b00, 1'b1, 1'b0, 1, 16'h003C, 1'b0);
        run_frame(16'hC3A1, 16, 2'b01, 1'b0, 1'b1, 2, 16'h9E57, 1'b0);
        run_frame(16'h000A, 4, 2'b10, 1'b1, 1'b1, 3, 16'h0009, 1'b0);
        run_frame(16'h0B6D, 12, 2'b11, 1'b0, 1'b0, 0, 16'h0AC3, 1'b0);
        // R7: clamping of out-of-range sizes
        run_frame(16'h000D, 2, 2'b00, 1'b1, 1'b1, 1, 16'h0006, 1'b0);
        run_frame(16'h8001, 20, 2'b01, 1'b1, 1'b0, 1, 16'hF00F, 1'b0);
        chk(1'b1, "R7", "clamped sizes covered above", 1, 1);
        // R8: start pulse inside a frame
        run_frame(16'h0093, 8, 2'b11, 1'b1, 1'b1, 1, 16'h00F0, 1'b1);
        t_start_disabled();
        t_disable_mid();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule